// File: doc/BRIEF.md
# Recursive IIR Interpolation Filter

This block raises the sample rate of a signed fixed-point stream by a fixed integer factor L and applies an anti-imaging recursive low-pass filter in the same stage. The filter is a parallel bank of first-order recursive sections whose outputs are summed. Up-sampling would normally insert L-1 zeros between samples and run the recursion on that stuffed stream. Here the recursion of each section is rewritten in terms of z^-L, so each section updates once per input sample, at the low rate. The up-sampling moves behind the sections: an output commutator steps through L phases, and phase k scales each section state by its pole raised to the power k.

An upstream producer offers samples with a valid/ready handshake. After each accepted sample the block presents L output samples, one per clock, and marks each with an output strobe and its phase index. It takes the next sample during the cycle that shows the final phase, so a producer that always offers data keeps the output stream full. Pole and gain of every section are Q1.15 elaboration parameters. Section states keep integer headroom and fraction bits. The output is rounded once and saturated to the input width.

Top module: `iir_upsampler`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is low, `out_phase` is 0, `in_ready` is high, and every section state is zero.
- R2: A sample is taken from `in_data` on a rising clock edge where `in_valid` and `in_ready` are both high.
- R3: Each accepted sample produces exactly L consecutive cycles with `out_valid` high. The first of these is the cycle after acceptance, and `out_phase` counts 0, 1, ..., L-1 in order.
- R4: `in_ready` is low while `out_valid` is high with `out_phase` below L-1. It is high when `out_valid` is low or when `out_phase` equals L-1.
- R5: Rounding is rnd_s(v) = floor((v + 2^(s-1)) / 2^s). P_k is the pole power built by P_0 = 2^15 and P_k = rnd_15(P_(k-1)·pole). On each acceptance, section state w (FRAC_W fraction bits, width DATA_W+HEAD_W+FRAC_W) becomes sat(rnd_15(P_L·w) + x·2^FRAC_W), saturated to the state width.
- R6: With C_k = rnd_15(gain·P_k), output phase k is sat_DATA_W(rnd_(15+FRAC_W)(sum over sections of C_k·w)).
- R7: Cycles without an acceptance leave all section states unchanged. The output sequence therefore equals, in exact arithmetic, each section's full-rate recursion y[n] = pole·y[n-1] + x_up[n] driven by the input stuffed with L-1 zeros, scaled by gain and summed.
- R8: Outputs above 2^(DATA_W-1)-1 or below -2^(DATA_W-1) are clamped to those limits.
- R9: `in_data` has no effect on any output when it is not accepted, including cycles where `in_valid` is high during a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | DATA_W | Signed, rounded, saturated output sample |
| out_phase | output | max(1,clog2(L)) | Commutator phase of the current output |

## Verification
The bench builds the block with L = 4 and two sections. One pole is +0.75. The other is -0.5, so its phase outputs change sign within a burst and a mistake in the phase-to-coefficient mapping shows at once. The gains are 0.99 and 0.5, which push the steady-state response of a full-scale step about twice past the output range, so both saturation limits are reached with ordinary input. L = 4 also gives the commutator a non-trivial counter width, and a back-to-back stream tests the hand-over between a final phase and the next acceptance.

// File: rtl/iir_interp_pkg.sv
package iir_interp_pkg;

   // Q1.15 coefficient format shared by all sections
   localparam int Q_FRAC = 15;
   localparam int COEF_W = 16;
   // expanded coefficient width: holds +1.0 and gain * pole^k products
   localparam int KW     = COEF_W + 2;

   typedef logic signed [COEF_W-1:0] coef_t;
   typedef logic signed [KW-1:0]     kcoef_t;

   // pole^n in Q1.15, built by repeated rounded products
   function automatic kcoef_t pole_power(input coef_t a, input int n);
      longint p;
      p = longint'(1) <<< Q_FRAC;
      for (int i = 0; i < n; i++) begin
         p = (p * longint'(a) + (longint'(1) <<< (Q_FRAC - 1))) >>> Q_FRAC;
      end
      return kcoef_t'(p);
   endfunction

   // gain * pole^k in Q1.15, one rounding after the power
   function automatic kcoef_t phase_coef(input coef_t a, input coef_t g, input int k);
      longint p;
      longint c;
      p = longint'(pole_power(a, k));
      c = (longint'(g) * p + (longint'(1) <<< (Q_FRAC - 1))) >>> Q_FRAC;
      return kcoef_t'(c);
   endfunction

endpackage

// File: rtl/iir_interp_seq.sv
module iir_interp_seq #(
   parameter int L    = 4,
   parameter int PH_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   output logic            in_ready,
   output logic            accept,
   output logic            busy,
   output logic [PH_W-1:0] phase
);

   logic last;

   assign last     = busy && (phase == PH_W'(L - 1));
   assign in_ready = !busy || last;
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         phase <= '0;
      end else if (accept) begin
         busy  <= 1'b1;
         phase <= '0;
      end else if (last) begin
         busy  <= 1'b0;
         phase <= '0;
      end else if (busy) begin
         phase <= phase + 1'b1;
      end
   end

endmodule

// File: rtl/iir_interp_section.sv
module iir_interp_section
   import iir_interp_pkg::*;
#(
   parameter int    DATA_W  = 16,
   parameter int    FRAC_W  = 8,
   parameter int    STATE_W = 28,
   parameter int    L       = 4,
   parameter int    PH_W    = 2,
   parameter coef_t POLE    = '0,
   parameter coef_t GAIN    = '0,
   parameter int    PROD_W  = KW + STATE_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic signed [DATA_W-1:0] x,
   input  logic [PH_W-1:0]          phase,
   output logic signed [PROD_W-1:0] tap
);

   localparam kcoef_t FB    = pole_power(POLE, L);
   localparam int     FB_W  = KW + STATE_W;
   localparam int     RND_W = FB_W - Q_FRAC;
   localparam int     SUM_W = ((RND_W > STATE_W) ? RND_W : STATE_W) + 1;
   localparam logic signed [FB_W-1:0]  FB_HALF = FB_W'(1) <<< (Q_FRAC - 1);
   localparam logic signed [SUM_W-1:0] S_MAX   = SUM_W'({1'b0, {(STATE_W-1){1'b1}}});
   localparam logic signed [SUM_W-1:0] S_MIN   = ~S_MAX;

   kcoef_t                    ctab [L];
   kcoef_t                    coef_sel;
   logic signed [STATE_W-1:0] w_q;
   logic signed [STATE_W-1:0] w_nxt;
   logic signed [FB_W-1:0]    fb_full;
   logic signed [FB_W-1:0]    fb_biased;
   logic signed [RND_W-1:0]   fb_rnd;
   logic signed [SUM_W-1:0]   w_sum;

   // per-phase output coefficients, folded gain * pole^k
   for (genvar k = 0; k < L; k++) begin : g_phase
      localparam kcoef_t CK = phase_coef(POLE, GAIN, k);
      assign ctab[k] = CK;
   end

   // recursion in z^-L: one update per accepted input
   always_comb begin
      fb_full   = FB_W'(FB) * FB_W'(w_q);
      fb_biased = fb_full + FB_HALF;
      fb_rnd    = RND_W'(fb_biased >>> Q_FRAC);
      w_sum     = SUM_W'(fb_rnd) + (SUM_W'(x) <<< FRAC_W);
      if (w_sum > S_MAX) begin
         w_nxt = S_MAX[STATE_W-1:0];
      end else if (w_sum < S_MIN) begin
         w_nxt = S_MIN[STATE_W-1:0];
      end else begin
         w_nxt = w_sum[STATE_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w_q <= '0;
      end else if (load) begin
         w_q <= w_nxt;
      end
   end

   // commutator leg: state scaled by this phase's coefficient
   always_comb begin
      coef_sel = (int'(phase) < L) ? ctab[phase] : '0;
      tap      = PROD_W'(coef_sel) * PROD_W'(w_q);
   end

endmodule

// File: rtl/iir_interp_combine.sv
module iir_interp_combine #(
   parameter int N_SEC  = 2,
   parameter int PROD_W = 46,
   parameter int DATA_W = 16,
   parameter int SHIFT  = 23
) (
   input  logic signed [PROD_W-1:0] taps [N_SEC],
   output logic signed [DATA_W-1:0] y
);

   localparam int ACC_W = PROD_W + $clog2(N_SEC) + 1;
   localparam logic signed [ACC_W-1:0] HALF  = ACC_W'(1) <<< (SHIFT - 1);
   localparam logic signed [ACC_W-1:0] Y_MAX = ACC_W'({1'b0, {(DATA_W-1){1'b1}}});
   localparam logic signed [ACC_W-1:0] Y_MIN = ~Y_MAX;

   logic signed [ACC_W-1:0] acc;
   logic signed [ACC_W-1:0] scaled;

   always_comb begin
      acc = HALF;
      for (int i = 0; i < N_SEC; i++) begin
         acc = acc + ACC_W'(taps[i]);
      end
      scaled = acc >>> SHIFT;
      if (scaled > Y_MAX) begin
         y = Y_MAX[DATA_W-1:0];
      end else if (scaled < Y_MIN) begin
         y = Y_MIN[DATA_W-1:0];
      end else begin
         y = scaled[DATA_W-1:0];
      end
   end

endmodule

// File: rtl/iir_upsampler.sv
module iir_upsampler
   import iir_interp_pkg::*;
#(
   parameter int    DATA_W = 16,
   parameter int    N_SEC  = 2,
   parameter int    L      = 4,
   parameter int    FRAC_W = 8,
   parameter int    HEAD_W = 4,
   parameter coef_t POLES [N_SEC] = '{16'sd24576, -16'sd16384},
   parameter coef_t GAINS [N_SEC] = '{16'sd32440, 16'sd16384},
   localparam int   PH_W   = (L > 1) ? $clog2(L) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   output logic                     in_ready,
   input  logic signed [DATA_W-1:0] in_data,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_data,
   output logic [PH_W-1:0]          out_phase
);

   localparam int STATE_W = DATA_W + HEAD_W + FRAC_W;
   localparam int PROD_W  = KW + STATE_W;

   // elaboration-time parameter checks
   if (L < 2) begin : g_bad_l
      $error("iir_upsampler: L must be at least 2");
   end
   if (N_SEC < 1) begin : g_bad_nsec
      $error("iir_upsampler: N_SEC must be at least 1");
   end
   if (FRAC_W < 1 || HEAD_W < 1) begin : g_bad_fmt
      $error("iir_upsampler: FRAC_W and HEAD_W must be positive");
   end
   if (PROD_W + $clog2(N_SEC) + 1 > 63) begin : g_bad_width
      $error("iir_upsampler: accumulator exceeds 63 bits");
   end

   logic                     accept;
   logic                     busy;
   logic [PH_W-1:0]          phase;
   logic signed [PROD_W-1:0] taps [N_SEC];

   iir_interp_seq #(
      .L    (L),
      .PH_W (PH_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .accept   (accept),
      .busy     (busy),
      .phase    (phase)
   );

   for (genvar i = 0; i < N_SEC; i++) begin : g_sec
      if (POLES[i] == -16'sd32768) begin : g_bad_pole
         $error("iir_upsampler: pole of -1.0 is not stable");
      end
      iir_interp_section #(
         .DATA_W  (DATA_W),
         .FRAC_W  (FRAC_W),
         .STATE_W (STATE_W),
         .L       (L),
         .PH_W    (PH_W),
         .POLE    (POLES[i]),
         .GAIN    (GAINS[i]),
         .PROD_W  (PROD_W)
      ) u_sec (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (accept),
         .x     (in_data),
         .phase (phase),
         .tap   (taps[i])
      );
   end

   iir_interp_combine #(
      .N_SEC  (N_SEC),
      .PROD_W (PROD_W),
      .DATA_W (DATA_W),
      .SHIFT  (Q_FRAC + FRAC_W)
   ) u_comb (
      .taps (taps),
      .y    (out_data)
   );

   assign out_valid = busy;
   assign out_phase = phase;

endmodule

// File: rtl/iir_upsampler_chk.sv
module iir_upsampler_chk #(
   parameter int L    = 4,
   parameter int PH_W = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic            in_ready,
   input logic            out_valid,
   input logic [PH_W-1:0] out_phase
);

   assert_idle_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);

   assert_busy_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_phase != PH_W'(L - 1)) |-> !in_ready);

   assert_first_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_valid && out_phase == '0));

   assert_phase_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_phase != PH_W'(L - 1)) |=>
         (out_valid && out_phase == PH_W'($past(out_phase) + 1'b1)));

   assert_burst_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_phase == PH_W'(L - 1) && !in_valid) |=> !out_valid);

   assert_idle_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_phase == '0));

endmodule

bind iir_upsampler iir_upsampler_chk #(
   .L    (L),
   .PH_W (PH_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_phase (out_phase)
);

// File: tb/test_iir_upsampler.sv
`timescale 1ns/1ps
module test_iir_upsampler;
   import iir_interp_pkg::*;

   localparam int DW = 16;
   localparam int NS = 2;
   localparam int LL = 4;
   localparam int FW = 8;
   localparam int HW = 4;
   localparam int PW = 2;
   localparam coef_t B_POLES [NS] = '{16'sd24576, -16'sd16384};
   localparam coef_t B_GAINS [NS] = '{16'sd32440, 16'sd16384};

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 in_valid = 1'b0;
   logic                 in_ready;
   logic signed [DW-1:0] in_data = '0;
   logic                 out_valid;
   logic signed [DW-1:0] out_data;
   logic [PW-1:0]        out_phase;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   int sat_hi = 0;
   int sat_lo = 0;
   bit done = 1'b0;

   // model state
   longint mw [NS];
   bit     m_valid = 1'b0;
   int     m_phase = 0;

   always #2 clk = ~clk;

   iir_upsampler #(
      .DATA_W (DW),
      .N_SEC  (NS),
      .L      (LL),
      .FRAC_W (FW),
      .HEAD_W (HW),
      .POLES  (B_POLES),
      .GAINS  (B_GAINS)
   ) i_iir_upsampler (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_phase (out_phase)
   );

   function automatic longint rnd(input longint v, input int s);
      return (v + (longint'(1) <<< (s - 1))) >>> s;
   endfunction

   function automatic longint clamp(input longint v, input longint lo, input longint hi);
      return (v > hi) ? hi : ((v < lo) ? lo : v);
   endfunction

   function automatic longint ppow(input longint a, input int n);
      longint p = 32768;
      for (int i = 0; i < n; i++) p = rnd(p * a, 15);
      return p;
   endfunction

   // state update on a non-zero slot of the zero-stuffed stream (R5)
   task automatic model_take(input longint x);
      longint smax = (longint'(1) <<< (DW + HW + FW - 1)) - 1;
      for (int i = 0; i < NS; i++) begin
         mw[i] = clamp(rnd(ppow(B_POLES[i], LL) * mw[i], 15) + (x <<< FW), -smax - 1, smax);
      end
   endtask

   // full-rate output at phase k after the last non-zero slot (R6)
   function automatic longint model_out(input int k);
      longint acc = 0;
      for (int i = 0; i < NS; i++) begin
         acc += rnd(longint'(B_GAINS[i]) * ppow(B_POLES[i], k), 15) * mw[i];
      end
      return clamp(rnd(acc, 15 + FW), -32768, 32767);
   endfunction

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < NS; i++) mw[i] = 0;
      m_valid = 1'b0;
      m_phase = 0;
   endtask

   // one clock: check outputs, drive inputs, check ready, advance model
   task automatic cyc(input bit v, input logic signed [DW-1:0] d);
      bit exp_ready;
      @(negedge clk);
      cycles++;
      check(out_valid === m_valid, "R3 out_valid", longint'(out_valid), longint'(m_valid));
      if (m_valid) begin
         check(int'(out_phase) == m_phase, "R3 out_phase", longint'(out_phase), longint'(m_phase));
         check(longint'(out_data) == model_out(m_phase), "R6/R7 out_data",
               longint'(out_data), model_out(m_phase));
         if (out_data == 16'sh7fff) sat_hi++;
         if (out_data == -16'sh8000) sat_lo++;
      end
      in_valid = v;
      in_data  = d;
      #1;
      exp_ready = !m_valid || (m_phase == LL - 1);
      check(in_ready === exp_ready, "R4 in_ready", longint'(in_ready), longint'(exp_ready));
      if (v && exp_ready) begin      // R2 acceptance; R9 otherwise ignored
         model_take(longint'(d));
         m_valid = 1'b1;
         m_phase = 0;
      end else if (m_valid && m_phase == LL - 1) begin
         m_valid = 1'b0;
         m_phase = 0;
      end else if (m_valid) begin
         m_phase++;
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 100000, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stim
      process::self().srandom(32'd1977);
      model_reset();
      // R1: reset values
      repeat (3) @(negedge clk);
      check(out_valid === 1'b0, "R1 out_valid in reset", longint'(out_valid), 0);
      check(in_ready === 1'b1, "R1 in_ready in reset", longint'(in_ready), 1);
      check(out_phase === '0, "R1 out_phase in reset", longint'(out_phase), 0);
      rst_n = 1'b1;

      // impulse from zero state (R3, R5, R6)
      cyc(1'b1, 16'sd1000);
      repeat (12) cyc(1'b0, '0);

      // R7: idle gap leaves state alone, then another sample
      repeat (20) cyc(1'b0, 16'sh5a5a);
      cyc(1'b1, -16'sd2500);
      repeat (6) cyc(1'b0, '0);

      // R9: valid held with changing data during bursts; only ready cycles count
      for (int n = 0; n < 40; n++) cyc(1'b1, DW'($urandom));

      // R8: full-scale positive and negative steps
      for (int n = 0; n < 60; n++) cyc(1'b1, 16'sh7fff);
      check(sat_hi > 0, "R8 positive clamp reached", sat_hi, 1);
      for (int n = 0; n < 80; n++) cyc(1'b1, -16'sh8000);
      check(sat_lo > 0, "R8 negative clamp reached", sat_lo, 1);

      // random traffic
      for (int n = 0; n < 1500; n++) begin
         cyc(($urandom % 10) < 6, DW'($urandom));
      end
      repeat (6) cyc(1'b0, '0);

      // R1: reset in the middle of a burst clears phase and state
      cyc(1'b1, 16'sd20000);
      cyc(1'b0, '0);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(out_valid === 1'b0, "R1 out_valid after mid-burst reset", longint'(out_valid), 0);
      check(in_ready === 1'b1, "R1 in_ready after mid-burst reset", longint'(in_ready), 1);
      model_reset();
      @(negedge clk);
      rst_n = 1'b1;
      cyc(1'b1, 16'sd1000);
      repeat (8) cyc(1'b0, '0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule